// File: doc/BRIEF.md
# Scalar Single and Double-Width Shifter

This block is the shift stage of a scalar datapath. It takes one 64-bit operand, or a pair of 64-bit operands joined into a 128-bit value, and moves the bits toward the most significant end (left) or toward the least significant end (right). Bits that leave the value are lost, and the positions they leave are filled with zeros. The amount comes either from a 6-bit immediate field or from a full register value.

The datapath passes the operand values together with the small register numbers (designators) they were read from. When a double-width shift names the same non-zero register for both operands and the amount is 64 or less, the block treats the pair as one register joined to itself. The outcome is then a rotation of that register.

The block is a fixed two-stage pipeline. It takes a new operation on every clock and delivers each result exactly two clocks after the operation is presented. Decoding and register-file access happen elsewhere.

Top module: `scalar_shifter`

## Requirements
- R1: Single mode (in_dbl=0), left (in_dir=0), count n below 64: the result is operand i shifted toward its most significant end by n places, with the low n bits zero.
- R2: Single mode, right (in_dir=1), count n below 64: the result is operand i shifted toward its least significant end by n places, with the high n bits zero.
- R3: Double mode (in_dbl=1) forms a 128-bit pair with operand i as the upper half and operand j as the lower half. For n below 128, a left shift returns the upper 64 bits of the pair shifted left by n, and a right shift returns the lower 64 bits of the pair shifted right by n, with zero fill.
- R4: In single mode any count of 64 or more gives an all-zero result.
- R5: In double mode, outside the circular case, any count of 128 or more gives an all-zero result.
- R6: In double mode, if n is at most 64 and both designators are equal and non-zero, operand i takes the place of operand j. The result is operand i rotated by n in the chosen direction, so a count of 64 returns operand i unchanged.
- R7: If the designators differ, if both are zero, or if n exceeds 64, a double shift uses operand j as given, with zero fill.
- R8: With in_use_imm=1 the count is the 6-bit in_imm field. With in_use_imm=0 the count is the whole in_reg_cnt value, compared at full width, so for example 256 counts as a huge amount rather than 0.
- R9: out_valid rises exactly two clocks after an in_valid cycle. Back-to-back operations produce back-to-back results, one per clock.
- R10: After reset, out_valid is 0 and out_data is 0. out_data keeps its last value while no result is being delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_dir | input | 1 | 0 = left (toward MSB), 1 = right |
| in_dbl | input | 1 | 0 = single 64-bit, 1 = double 128-bit |
| in_opnd_i | input | DATA_W | Operand i (upper half of the pair) |
| in_opnd_j | input | DATA_W | Operand j (lower half of the pair) |
| in_dsg_i | input | DSG_W | Register number of operand i |
| in_dsg_j | input | DSG_W | Register number of operand j |
| in_use_imm | input | 1 | 1 = count from in_imm, 0 = from in_reg_cnt |
| in_imm | input | IMM_W | Immediate count |
| in_reg_cnt | input | CNT_W | Register count value |
| out_valid | output | 1 | Result valid |
| out_data | output | DATA_W | Shift result |

## Verification
The circular substitution and the zero-saturation of large counts can both apply to one double-width operation. This happens at the count boundary of 64, 65 and at the top of the register range, with equal non-zero designators. The bench provokes these cases directly, with counts 64 and 65 on equal designators, with zero designators, and with a 256 register value. Random operations with a high share of equal designators and counts near the boundaries add more such cases. Each result is compared with a bench model that computes every output bit separately from the pair. Operations are issued back to back and with gaps, so the two-clock latency and the held output are judged in the same run.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic {
    SHF_LEFT  = 1'b0,
    SHF_RIGHT = 1'b1
  } shf_dir_e;

  typedef enum logic {
    SHF_SINGLE = 1'b0,
    SHF_DOUBLE = 1'b1
  } shf_mode_e;
endpackage

// File: rtl/shf_count_sel.sv
module shf_count_sel #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 24,
  parameter int IMM_W  = 6,
  localparam int LIMIT = 2 * DATA_W,
  localparam int EFF_W = $clog2(LIMIT) + 1
) (
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [CNT_W-1:0] reg_cnt,
  output logic [EFF_W-1:0] eff_cnt
);
  // Clamp any amount that empties the 128-bit pair to exactly LIMIT
  function automatic logic [EFF_W-1:0] sat_count(input logic [CNT_W-1:0] raw);
    if (raw >= CNT_W'(LIMIT)) sat_count = EFF_W'(LIMIT);
    else                      sat_count = raw[EFF_W-1:0];
  endfunction

  logic [CNT_W-1:0] raw_cnt;

  always_comb begin
    raw_cnt = use_imm ? {{(CNT_W-IMM_W){1'b0}}, imm} : reg_cnt;
    eff_cnt = sat_count(raw_cnt);
  end
endmodule

// File: rtl/shf_operand_sel.sv
module shf_operand_sel
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DSG_W  = 3,
  localparam int EFF_W = $clog2(2 * DATA_W) + 1
) (
  input  shf_dir_e          dir,
  input  shf_mode_e         mode,
  input  logic [DSG_W-1:0]  dsg_i,
  input  logic [DSG_W-1:0]  dsg_j,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] opnd_j,
  input  logic [EFF_W-1:0]  eff_cnt,
  output logic [DATA_W-1:0] pair_hi,
  output logic [DATA_W-1:0] pair_lo,
  output logic              ring
);
  function automatic logic is_ring(input shf_mode_e m,
                                   input logic [DSG_W-1:0] a,
                                   input logic [DSG_W-1:0] b,
                                   input logic [EFF_W-1:0] n);
    is_ring = (m == SHF_DOUBLE) && (a == b) && (a != '0) &&
              (n <= EFF_W'(DATA_W));
  endfunction

  always_comb begin
    ring = is_ring(mode, dsg_i, dsg_j, eff_cnt);
    if (mode == SHF_DOUBLE) begin
      pair_hi = opnd_i;
      pair_lo = ring ? opnd_i : opnd_j;
    end else if (dir == SHF_LEFT) begin
      pair_hi = opnd_i;
      pair_lo = '0;
    end else begin
      pair_hi = '0;
      pair_lo = opnd_i;
    end
  end
endmodule

// File: rtl/shf_funnel.sv
module shf_funnel
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int PW    = 2 * DATA_W,
  localparam int STG   = $clog2(PW),
  localparam int EFF_W = STG + 1
) (
  input  shf_dir_e          dir,
  input  logic [DATA_W-1:0] pair_hi,
  input  logic [DATA_W-1:0] pair_lo,
  input  logic [EFF_W-1:0]  cnt,
  output logic [DATA_W-1:0] res
);
  logic [PW-1:0] stg [0:STG];

  assign stg[0] = {pair_hi, pair_lo};

  for (genvar s = 0; s < STG; s++) begin : g_stage
    localparam int AMT = 1 << s;
    assign stg[s+1] = !cnt[s]          ? stg[s] :
                      (dir == SHF_LEFT) ? (stg[s] << AMT) : (stg[s] >> AMT);
  end

  always_comb begin
    if (cnt[EFF_W-1])          res = '0;
    else if (dir == SHF_LEFT)  res = stg[STG][PW-1 -: DATA_W];
    else                       res = stg[STG][DATA_W-1:0];
  end
endmodule

// File: rtl/scalar_shifter.sv
module scalar_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DSG_W  = 3,
  parameter int IMM_W  = 6,
  parameter int CNT_W  = 24,
  localparam int EFF_W = $clog2(2 * DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_dir,
  input  logic              in_dbl,
  input  logic [DATA_W-1:0] in_opnd_i,
  input  logic [DATA_W-1:0] in_opnd_j,
  input  logic [DSG_W-1:0]  in_dsg_i,
  input  logic [DSG_W-1:0]  in_dsg_j,
  input  logic              in_use_imm,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [CNT_W-1:0]  in_reg_cnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  // Front stage: count clamp and operand pairing
  logic [EFF_W-1:0]  fe_cnt;
  logic [DATA_W-1:0] fe_hi, fe_lo;
  logic              fe_ring;

  shf_count_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_cnt (
    .use_imm (in_use_imm),
    .imm     (in_imm),
    .reg_cnt (in_reg_cnt),
    .eff_cnt (fe_cnt)
  );

  shf_operand_sel #(.DATA_W(DATA_W), .DSG_W(DSG_W)) u_opsel (
    .dir     (shf_dir_e'(in_dir)),
    .mode    (shf_mode_e'(in_dbl)),
    .dsg_i   (in_dsg_i),
    .dsg_j   (in_dsg_j),
    .opnd_i  (in_opnd_i),
    .opnd_j  (in_opnd_j),
    .eff_cnt (fe_cnt),
    .pair_hi (fe_hi),
    .pair_lo (fe_lo),
    .ring    (fe_ring)
  );

  // Middle register: named so the checker can watch it
  logic              mid_valid;
  shf_dir_e          mid_dir;
  logic              mid_dbl;
  logic [DATA_W-1:0] mid_hi, mid_lo;
  logic [EFF_W-1:0]  mid_cnt;
  logic              mid_ring;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_valid <= 1'b0;
      mid_dir   <= SHF_LEFT;
      mid_dbl   <= 1'b0;
      mid_hi    <= '0;
      mid_lo    <= '0;
      mid_cnt   <= '0;
      mid_ring  <= 1'b0;
    end else begin
      mid_valid <= in_valid;
      if (in_valid) begin
        mid_dir  <= shf_dir_e'(in_dir);
        mid_dbl  <= in_dbl;
        mid_hi   <= fe_hi;
        mid_lo   <= fe_lo;
        mid_cnt  <= fe_cnt;
        mid_ring <= fe_ring;
      end
    end
  end

  // Back stage: staged funnel, then the output register
  logic [DATA_W-1:0] be_res;

  shf_funnel #(.DATA_W(DATA_W)) u_funnel (
    .dir     (mid_dir),
    .pair_hi (mid_hi),
    .pair_lo (mid_lo),
    .cnt     (mid_cnt),
    .res     (be_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= mid_valid;
      if (mid_valid) out_data <= be_res;
    end
  end
endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
  parameter int DATA_W = 64,
  parameter int EFF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mid_valid,
  input logic              mid_dbl,
  input logic              mid_ring,
  input logic [EFF_W-1:0]  mid_cnt,
  input logic [DATA_W-1:0] mid_hi,
  input logic [DATA_W-1:0] mid_lo,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(mid_valid));

  a_r4_single_wide_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_valid && !mid_dbl && mid_cnt >= EFF_W'(DATA_W)) |=> out_data == '0);

  a_r5_saturated_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_valid && mid_cnt == EFF_W'(2 * DATA_W)) |=> out_data == '0);

  a_r6_ring_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_valid && mid_ring) |=> $countones(out_data) == $countones($past(mid_hi)));

  // R1 / R2: zero count passes the single operand through
  a_r1_zero_count_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_valid && !mid_dbl && mid_cnt == '0) |=> out_data == $past(mid_hi | mid_lo));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mid_valid |=> $stable(out_data));
endmodule

bind scalar_shifter shf_checker #(.DATA_W(DATA_W), .EFF_W(EFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mid_valid (mid_valid),
  .mid_dbl   (mid_dbl),
  .mid_ring  (mid_ring),
  .mid_cnt   (mid_cnt),
  .mid_hi    (mid_hi),
  .mid_lo    (mid_lo),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/scalar_shifter_test.sv
`timescale 1ns/1ps
module scalar_shifter_test;
  localparam int DW = 64;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_dir = 1'b0, in_dbl = 1'b0, in_use_imm = 1'b0;
  logic [DW-1:0] in_opnd_i = '0, in_opnd_j = '0;
  logic [2:0]    in_dsg_i = '0, in_dsg_j = '0;
  logic [5:0]    in_imm = '0;
  logic [23:0]   in_reg_cnt = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  scalar_shifter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dir(in_dir),
    .in_dbl(in_dbl), .in_opnd_i(in_opnd_i), .in_opnd_j(in_opnd_j),
    .in_dsg_i(in_dsg_i), .in_dsg_j(in_dsg_j), .in_use_imm(in_use_imm),
    .in_imm(in_imm), .in_reg_cnt(in_reg_cnt),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // two-deep record of issued operations
  bit            p1_v = 0, p2_v = 0;
  logic [DW-1:0] p1_d = '0, p2_d = '0, last_d = '0;
  string         p1_t = "", p2_t = "";

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff_count(bit use_imm, logic [5:0] imm, logic [23:0] rc);
    return use_imm ? int'(imm) : int'(rc);
  endfunction

  function automatic bit circ(bit dbl, logic [2:0] di, logic [2:0] dj, int n);
    return dbl && di == dj && di != 0 && n <= 64;
  endfunction

  // Bit-by-bit model: each output bit picks its source position
  function automatic logic [DW-1:0] model(logic [DW-1:0] a, logic [DW-1:0] b,
      logic [2:0] di, logic [2:0] dj, bit dir, bit dbl, int n);
    logic [127:0]  p;
    logic [DW-1:0] r = '0;
    if (!dbl) begin
      for (int k = 0; k < 64; k++) begin
        int s = dir ? k + n : k - n;
        r[k] = (s >= 0 && s < 64) ? a[s] : 1'b0;
      end
    end else begin
      p = {a, circ(dbl, di, dj, n) ? a : b};
      for (int k = 0; k < 64; k++) begin
        int s = dir ? k + n : k + 64 - n;
        r[k] = (s >= 0 && s < 128) ? p[s] : 1'b0;
      end
    end
    return r;
  endfunction

  function automatic string tag_of(bit use_imm, logic [2:0] di, logic [2:0] dj,
      bit dir, bit dbl, int n);
    if (!use_imm && n >= 128)             return "R8";
    if (circ(dbl, di, dj, n))             return "R6";
    if (dbl && n >= 128)                  return "R5";
    if (!dbl && n >= 64)                  return "R4";
    if (dbl && (di != dj || di == 0 || n > 64)) return "R7";
    if (dbl)                              return "R3";
    return dir ? "R2" : "R1";
  endfunction

  // One cycle: judge the result of two cycles ago, then drive new inputs
  task automatic step(bit v, bit dir, bit dbl, logic [DW-1:0] a, logic [DW-1:0] b,
      logic [2:0] di, logic [2:0] dj, bit use_imm, logic [5:0] imm, logic [23:0] rc);
    int n;
    @(negedge clk);
    if (p2_v) begin
      check("R9 out_valid", {63'd0, out_valid}, 64'd1);
      check(p2_t, out_data, p2_d);
      last_d = p2_d;
    end else begin
      check("R9 out_valid idle", {63'd0, out_valid}, 64'd0);
      check("R10 hold", out_data, last_d);
    end
    p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
    n = eff_count(use_imm, imm, rc);
    p1_v = v;
    p1_d = model(a, b, di, dj, dir, dbl, n);
    p1_t = tag_of(use_imm, di, dj, dir, dbl, n);
    in_valid = v; in_dir = dir; in_dbl = dbl; in_opnd_i = a; in_opnd_j = b;
    in_dsg_i = di; in_dsg_j = dj; in_use_imm = use_imm; in_imm = imm; in_reg_cnt = rc;
  endtask

  localparam logic [DW-1:0] A = 64'h8123_4567_89AB_CDEF;
  localparam logic [DW-1:0] B = 64'hF0E1_D2C3_B4A5_9687;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset data", out_data, 64'd0);
    rst_n = 1'b1;
    // directed: R1, R2 single
    step(1, 0, 0, A, B, 1, 2, 1, 6'd0, 0);
    step(1, 0, 0, A, B, 1, 2, 1, 6'd4, 0);
    step(1, 1, 0, A, B, 1, 2, 1, 6'd63, 0);
    step(1, 1, 0, A, B, 1, 2, 0, 6'd0, 24'd17);
    // R4 single large counts
    step(1, 0, 0, A, B, 1, 2, 0, 6'd0, 24'd64);
    step(1, 1, 0, A, B, 1, 2, 0, 6'd0, 24'd100);
    // R3 double, differing designators
    step(1, 0, 1, A, B, 1, 2, 1, 6'd8, 0);
    step(1, 1, 1, A, B, 1, 2, 1, 6'd8, 0);
    step(1, 0, 1, A, B, 3, 4, 0, 6'd0, 24'd127);
    step(1, 1, 1, A, B, 3, 4, 0, 6'd0, 24'd64);
    // R5 double saturation, R8 full-width register count
    step(1, 0, 1, A, B, 3, 4, 0, 6'd0, 24'd128);
    step(1, 1, 1, A, B, 5, 5, 0, 6'd0, 24'd256);
    step(1, 0, 0, A, B, 5, 5, 0, 6'd0, 24'h80_0000);
    // R6 rotate cases
    step(1, 0, 1, A, B, 6, 6, 1, 6'd12, 0);
    step(1, 1, 1, A, B, 6, 6, 1, 6'd12, 0);
    step(1, 0, 1, A, B, 6, 6, 0, 6'd0, 24'd64);
    step(1, 1, 1, A, B, 7, 7, 0, 6'd0, 24'd64);
    // R7 no rotate: zero designators, count 65
    step(1, 0, 1, A, B, 0, 0, 1, 6'd12, 0);
    step(1, 0, 1, A, B, 6, 6, 0, 6'd0, 24'd65);
    step(1, 1, 1, A, B, 6, 6, 0, 6'd0, 24'd65);
    // gaps for R9 / R10
    step(0, 0, 0, '0, '0, 0, 0, 0, 6'd0, 0);
    step(0, 1, 1, B, A, 2, 2, 1, 6'd3, 0);
    step(1, 1, 0, B, A, 2, 2, 1, 6'd3, 0);
    step(0, 0, 0, '0, '0, 0, 0, 0, 6'd0, 0);
    // random mix
    for (int t = 0; t < 3000; t++) begin
      logic [2:0]  di = 3'($urandom_range(0, 7));
      logic [2:0]  dj = ($urandom_range(0, 1) == 1) ? di : 3'($urandom_range(0, 7));
      logic [23:0] rc = ($urandom_range(0, 7) == 0) ? 24'($urandom)
                                                    : 24'($urandom_range(0, 140));
      step($urandom_range(0, 4) != 0, 1'($urandom), 1'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom}, di, dj,
           1'($urandom), 6'($urandom), rc);
    end
    repeat (4) step(0, 0, 0, '0, '0, 0, 0, 0, 6'd0, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule